// File: doc/BRIEF.md
# Exception Cause and Vector Selector

This unit collects the raw exception conditions of a processor pipeline: instruction-fetch translation results, decode flags, the alignment checker, the trap comparator, the external interrupt pin and the decrementer register. It decides each cycle whether an exception is taken and, if so, which one. Its outputs are a take strobe, the 20-bit vector offset of the handler and a vector of cause bits that the surrounding logic saves in its save/restore status register.

The unit detects the rising edge of the decrementer's most significant bit itself. It holds that request as pending until the decrementer exception is accepted. External and decrementer interrupts are gated by the external-enable state bit. The privileged-instruction check also catches special-register moves whose register field has its top bit set while the core is in user state. When several conditions coincide, one fixed priority picks the winner.

All outputs are registered. The result for the conditions present before a clock edge appears after that edge.

Top module: `exc_vector_sel`

## Requirements
- R1: Any fetch fault (translation miss, direct-store fetch or protection violation) selects vector 0x00400. Cause bit 1 marks the translation miss, bit 3 the direct-store fetch and bit 4 the protection violation, and every one of them that is present is set.
- R2: Illegal opcode, privileged fault or trap match selects vector 0x00700. Cause bit 12 marks illegal, bit 13 privileged and bit 14 trap, and every one present is set.
- R3: A privileged fault exists only in user state. It is raised by a privileged instruction, or by a special-register move with an invalid field whose top field bit is 1. In supervisor state, or when that top bit is 0, no fault results.
- R4: A floating-point instruction selects vector 0x00800 when the FP-available bit is 0. It raises no exception when that bit is 1.
- R5: An alignment fault selects vector 0x00600 and a system call selects vector 0x00C00.
- R6: The external pin selects vector 0x00500 only while external-enable is 1. Otherwise it has no effect.
- R7: A 0-to-1 transition of the decrementer MSB (whose previous value is 0 after reset) creates a request that stays pending until it is taken. It is taken at vector 0x00900 only while external-enable is 1, and taking it clears the pending request.
- R8: When several causes coincide, the priority is fetch > program > FP-unavailable > alignment > system call > external > decrementer.
- R9: Outputs reflect the inputs sampled at the previous clock edge. With no exception, the strobe, the vector and the cause bits are all 0. Non-fetch, non-program vectors carry zero cause bits. Reset clears all outputs and state, and no vector in 0x00A00–0x00BFF is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_miss | input | 1 | Fetch address could not be translated |
| fetch_dstore | input | 1 | Fetch targets a direct-store segment |
| fetch_prot | input | 1 | Fetch violates memory protection |
| op_illegal | input | 1 | Illegal or unimplemented opcode |
| op_priv | input | 1 | Privileged instruction decoded |
| op_spr_bad | input | 1 | Special-register move with invalid field |
| op_spr_top | input | 1 | Top bit of the special-register field |
| op_fp | input | 1 | Floating-point instruction decoded |
| op_sc | input | 1 | System call instruction decoded |
| align_fault | input | 1 | Alignment checker flags the access |
| trap_hit | input | 1 | Trap condition met |
| st_ee | input | 1 | External-enable state bit |
| st_fp | input | 1 | FP-available state bit |
| st_user | input | 1 | Problem (user) state bit |
| irq_pin | input | 1 | External interrupt input |
| dec_value | input | DEC_W | Decrementer register value |
| take_exc | output | 1 | Exception taken strobe |
| vec_off | output | VEC_W | Handler vector offset |
| cause | output | CAUSE_W | Cause bits for the status register |

## Verification
The bench builds the unit with an 8-bit decrementer and the default vector and cause widths. The short decrementer lets the bench drive MSB transitions directly. Pending decrementer requests can be held behind disabled interrupts or higher-priority causes and released later. Every single cause and every pair of causes is driven, followed by a long stretch of mixed random conditions. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter int DEC_W   = 32,
  parameter int VEC_W   = 20,
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_miss,
  input  logic               fetch_dstore,
  input  logic               fetch_prot,
  input  logic               op_illegal,
  input  logic               op_priv,
  input  logic               op_spr_bad,
  input  logic               op_spr_top,
  input  logic               op_fp,
  input  logic               op_sc,
  input  logic               align_fault,
  input  logic               trap_hit,
  input  logic               st_ee,
  input  logic               st_fp,
  input  logic               st_user,
  input  logic               irq_pin,
  input  logic [DEC_W-1:0]   dec_value,
  output logic               take_exc,
  output logic [VEC_W-1:0]   vec_off,
  output logic [CAUSE_W-1:0] cause
);

  localparam logic [VEC_W-1:0] V_FETCH = VEC_W'(20'h00400);
  localparam logic [VEC_W-1:0] V_EXT   = VEC_W'(20'h00500);
  localparam logic [VEC_W-1:0] V_ALIGN = VEC_W'(20'h00600);
  localparam logic [VEC_W-1:0] V_PROG  = VEC_W'(20'h00700);
  localparam logic [VEC_W-1:0] V_FPU   = VEC_W'(20'h00800);
  localparam logic [VEC_W-1:0] V_DEC   = VEC_W'(20'h00900);
  localparam logic [VEC_W-1:0] V_SC    = VEC_W'(20'h00C00);
  localparam int C_MISS = 1, C_DSTORE = 3, C_PROT = 4;
  localparam int C_ILL = 12, C_PRIV = 13, C_TRAP = 14;

  logic dec_msb_q, dec_pend;
  logic fetch_f, priv_f, prog_f, fpu_f, ext_f, dec_edge, dec_req, dec_f, dec_take;
  logic               sel_any;
  logic [VEC_W-1:0]   sel_vec;
  logic [CAUSE_W-1:0] sel_cause;

  assign fetch_f  = fetch_miss | fetch_dstore | fetch_prot;
  assign priv_f   = st_user & (op_priv | (op_spr_bad & op_spr_top));
  assign prog_f   = op_illegal | priv_f | trap_hit;
  assign fpu_f    = op_fp & ~st_fp;
  assign ext_f    = st_ee & irq_pin;
  assign dec_edge = dec_value[DEC_W-1] & ~dec_msb_q;
  assign dec_req  = dec_pend | dec_edge;
  assign dec_f    = st_ee & dec_req;
  assign dec_take = dec_f & ~(fetch_f | prog_f | fpu_f | align_fault | op_sc | ext_f);

  always_comb begin
    sel_any   = 1'b1;
    sel_vec   = '0;
    sel_cause = '0;
    if (fetch_f) begin
      sel_vec = V_FETCH;
      sel_cause[C_MISS]   = fetch_miss;
      sel_cause[C_DSTORE] = fetch_dstore;
      sel_cause[C_PROT]   = fetch_prot;
    end else if (prog_f) begin
      sel_vec = V_PROG;
      sel_cause[C_ILL]  = op_illegal;
      sel_cause[C_PRIV] = priv_f;
      sel_cause[C_TRAP] = trap_hit;
    end else if (fpu_f)       sel_vec = V_FPU;
    else if (align_fault)     sel_vec = V_ALIGN;
    else if (op_sc)           sel_vec = V_SC;
    else if (ext_f)           sel_vec = V_EXT;
    else if (dec_f)           sel_vec = V_DEC;
    else                      sel_any = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_msb_q <= 1'b0;
      dec_pend  <= 1'b0;
      take_exc  <= 1'b0;
      vec_off   <= '0;
      cause     <= '0;
    end else begin
      dec_msb_q <= dec_value[DEC_W-1];
      dec_pend  <= dec_req & ~dec_take;
      take_exc  <= sel_any;
      vec_off   <= sel_vec;
      cause     <= sel_cause;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> (vec_off == '0 && cause == '0)); // R9
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> !(vec_off >= VEC_W'(20'h00A00) && vec_off <= VEC_W'(20'h00BFF))); // R9
  AST_FETCH_BITS_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && (cause[C_DSTORE] || cause[C_PROT])) |-> vec_off == V_FETCH); // R1
  AST_EXT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_off == V_EXT) |-> $past(st_ee && irq_pin)); // R6
  AST_FPU_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_off == V_FPU) |-> !$past(st_fp)); // R4
  AST_DEC_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_off == V_DEC) |-> !dec_pend); // R7
  AST_PRIV_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && cause[C_PRIV]) |-> $past(st_user)); // R3

endmodule

// File: tb/exc_vector_sel_test.sv
module exc_vector_sel_test;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0;
  logic fetch_miss, fetch_dstore, fetch_prot, op_illegal, op_priv, op_spr_bad, op_spr_top;
  logic op_fp, op_sc, align_fault, trap_hit, st_ee, st_fp, st_user, irq_pin;
  logic [DW-1:0] dec_value;
  logic take_exc;
  logic [19:0] vec_off;
  logic [15:0] cause;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R9";

  exc_vector_sel #(.DEC_W(DW)) uut (.*);

  always #2 clk = ~clk;

  bit exp_take; int exp_vec; int exp_cause;
  bit m_prev_msb, m_pend;

  function automatic string tag_of(int v);
    case (v)
      'h400: return "R1"; 'h700: return "R2"; 'h800: return "R4";
      'h600, 'hC00: return "R5"; 'h500: return "R6"; 'h900: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_take = 0; exp_vec = 0; exp_cause = 0; m_prev_msb = 0; m_pend = 0;
    end else begin
      bit req [7]; int vecs [7]; bit priv, dreq; int win;
      priv = st_user && (op_priv || (op_spr_bad && op_spr_top));
      dreq = m_pend || (dec_value[DW-1] && !m_prev_msb);
      req[0] = fetch_miss || fetch_dstore || fetch_prot;        vecs[0] = 'h400;
      req[1] = op_illegal || priv || trap_hit;                  vecs[1] = 'h700;
      req[2] = op_fp && !st_fp;                                 vecs[2] = 'h800;
      req[3] = align_fault;                                     vecs[3] = 'h600;
      req[4] = op_sc;                                           vecs[4] = 'hC00;
      req[5] = st_ee && irq_pin;                                vecs[5] = 'h500;
      req[6] = st_ee && dreq;                                   vecs[6] = 'h900;
      win = -1;
      for (int k = 6; k >= 0; k--) if (req[k]) win = k;
      exp_take = (win >= 0);
      exp_vec = (win >= 0) ? vecs[win] : 0;
      exp_cause = 0;
      if (win == 0) exp_cause = (fetch_miss << 1) | (fetch_dstore << 3) | (fetch_prot << 4);
      if (win == 1) exp_cause = (op_illegal << 12) | (priv << 13) | (trap_hit << 14);
      m_pend = dreq && !(win == 6);
      m_prev_msb = dec_value[DW-1];
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (take_exc !== exp_take || vec_off !== 20'(exp_vec) || cause !== 16'(exp_cause)) begin
      fails++;
      $display("FAIL %s/%s: take=%0b vec=%h cause=%h expected take=%0b vec=%h cause=%h",
               cur_req, tag_of(exp_vec), take_exc, vec_off, cause, exp_take, exp_vec[19:0], exp_cause[15:0]);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle();
    {fetch_miss, fetch_dstore, fetch_prot, op_illegal, op_priv, op_spr_bad, op_spr_top} = '0;
    {op_fp, op_sc, align_fault, trap_hit, irq_pin} = '0;
    st_ee = 0; st_fp = 1; st_user = 0; dec_value = '0;
  endtask

  task automatic apply(int k);
    case (k)
      0: fetch_miss = 1;   1: fetch_dstore = 1;  2: fetch_prot = 1;
      3: op_illegal = 1;   4: begin op_priv = 1; st_user = 1; end
      5: begin op_spr_bad = 1; op_spr_top = 1; st_user = 1; end
      6: trap_hit = 1;     7: begin op_fp = 1; st_fp = 0; end
      8: align_fault = 1;  9: op_sc = 1;
      10: begin irq_pin = 1; st_ee = 1; end
      default: begin dec_value = 8'h80; st_ee = 1; end
    endcase
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    idle();
    repeat (3) step();
    cur_req = "R9";  // reset state checked by per-cycle compare
    rst_n = 1;
    step(); step();
    // R1 R2 R4 R5 R6 R7: single causes
    for (int k = 0; k < 12; k++) begin
      cur_req = (k < 3) ? "R1" : (k < 7) ? "R2" : (k == 7) ? "R4" : (k < 10) ? "R5" : (k == 10) ? "R6" : "R7";
      idle(); apply(k); step(); idle(); step(); step();
    end
    // R8: all pairs
    cur_req = "R8";
    for (int a = 0; a < 12; a++)
      for (int b = a + 1; b < 12; b++) begin
        idle(); apply(a); apply(b); step(); idle(); st_ee = 1; step(); idle(); step();
      end
    // R3: no privileged fault in supervisor state or with top field bit 0
    cur_req = "R3";
    idle(); op_priv = 1; step();
    idle(); op_spr_bad = 1; op_spr_top = 1; step();
    idle(); op_spr_bad = 1; st_user = 1; step();
    idle(); op_spr_bad = 1; op_spr_top = 1; st_user = 1; step();
    // R4: FP available means no exception
    cur_req = "R4";
    idle(); op_fp = 1; st_fp = 1; step();
    // R6: pin ignored while disabled
    cur_req = "R6";
    idle(); irq_pin = 1; step(); step();
    // R7: edge while disabled stays pending, taken once enabled, then cleared
    cur_req = "R7";
    idle(); dec_value = 8'h80; step();
    dec_value = 8'hFF; step(); step();
    st_ee = 1; step();
    step(); step();
    idle(); dec_value = 8'h80; align_fault = 1; st_ee = 1; step();
    idle(); st_ee = 1; step(); step();
    // R9: mixed random stream
    cur_req = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      fetch_miss = (r[3:0] == 0); fetch_dstore = (r[7:4] == 0); fetch_prot = (r[11:8] == 0);
      op_illegal = (r[14:12] == 0); op_priv = r[15]; op_spr_bad = r[16]; op_spr_top = r[17];
      op_fp = r[18]; op_sc = (r[21:19] == 0); align_fault = (r[24:22] == 0); trap_hit = (r[27:25] == 0);
      st_ee = r[28]; st_fp = r[29]; st_user = r[30]; irq_pin = r[31];
      dec_value = 8'($urandom);
      step();
    end
    idle(); step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule